// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller with Auto-Reload

This block moves single words between peripheral devices and data memory. It takes one bus cycle at a time from the host CPU. Each channel holds a programmed start address and a word count. When a device pulses its request line, the controller raises a bus request and waits for the CPU to hand over the bus. It then presents the memory address for one cycle and pulses that channel's device-activate strobe. A separate peripheral data controller acts on that strobe and moves the data word across the shared data bus. The controller itself never touches data; its only part in a transfer is to supply the address.

A channel runs in one of two modes. In one-shot mode it steps through its buffer once, then disables itself and signals completion. In circular mode, when the buffer is used up, it restores both the start address and the count from the programmed values and stays armed. Pending requests from several channels are served lowest channel number first, one word per bus grant. The bus is handed back after every word.

Top module: `dma_steal`

## Requirements
- R1: After a synchronous active-high reset, `bus_req`, `addr_valid`, `dev_strobe` and `done` are low, and every channel reads back with a current address of 0, a current count of 0 and a control value of 0 (disabled).
- R2: A write with `cfg_sel`=0 loads a channel's start address and its current address. `cfg_sel`=1 loads its length and current count. `cfg_sel`=2 loads control, with bit 0 as enable and bit 1 as circular mode. A read selects `rd_sel`=0 for the current address, 1 for the current count and 2 for control {circular, enable}, and the value appears on `rd_data` one clock later.
- R3: An accepted request raises `bus_req`. No strobe or valid address appears while `bus_grant` is low.
- R4: One clock edge after `bus_grant` is seen high in the request state, `addr_valid` is high for exactly one cycle. During that cycle `dma_addr` holds the channel's current address and only that channel's `dev_strobe` bit is set. `bus_req` falls on the next edge, and no new request is raised until `bus_grant` has gone low.
- R5: Each word moved adds one to the channel's current address and subtracts one from its current count.
- R6: In one-shot mode, the word that brings the count to zero clears the channel's enable bit. The same word pulses that channel's `done` bit for one cycle, in the cycle of its strobe.
- R7: In circular mode, the word that exhausts the count reloads the current address and count from the programmed start address and length. The channel stays enabled and `done` is not pulsed.
- R8: When several channels have pending requests, the lowest-numbered one is served first, with one word per bus grant.
- R9: A request on a channel that is disabled or whose current count is zero is dropped: `bus_req` stays low and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register written: 0 start address, 1 length, 2 control |
| cfg_wdata | input | 16 | Write data |
| rd_ch | input | 2 | Channel addressed by the read |
| rd_sel | input | 2 | Register read: 0 current address, 1 current count, 2 control |
| rd_data | output | 16 | Registered read data |
| dev_req | input | 4 | Per-channel device request pulses |
| bus_grant | input | 1 | High while the CPU has released the bus |
| bus_req | output | 1 | Bus request toward the CPU |
| dma_addr | output | 16 | Memory address of the word being moved |
| addr_valid | output | 1 | High in the single transfer cycle |
| dev_strobe | output | 4 | One-hot device-activate strobe to the peripheral data controller |
| done | output | 4 | One-cycle pulse when a one-shot channel finishes |

## Verification
A request pulse sampled at edge N sets the pending bit, and `bus_req` is high after edge N+1. The strobe, address and `done` pulse appear one edge after the first edge at which `bus_grant` is high, and `bus_req` falls one edge later. Register reads return one edge after the select is driven. The bench drives on falling edges and samples on falling edges. A CPU stub raises `bus_grant` a chosen number of cycles after `bus_req`. The scoreboard holds, in service order, the expected channel, address and `done` value for each accepted request, and the monitor compares each strobe cycle against the head of that queue. It also checks `bus_req` on the falling edge after each strobe.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_REQ  = 2'd1,
    BS_XFER = 2'd2,
    BS_REL  = 2'd3
  } bus_state_t;

  localparam logic [1:0] WR_BASE = 2'd0;
  localparam logic [1:0] WR_LEN  = 2'd1;
  localparam logic [1:0] WR_CTRL = 2'd2;

  localparam logic [1:0] RD_ADDR = 2'd0;
  localparam logic [1:0] RD_CNT  = 2'd1;
  localparam logic [1:0] RD_CTRL = 2'd2;
endpackage

// File: rtl/dma_steal_chan.sv
module dma_steal_chan
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          dev_req,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] cur_cnt,
  output logic          en,
  output logic          circ,
  output logic          ready,
  output logic          done
);
  logic [AW-1:0] base;
  logic [LW-1:0] len;
  logic          pend;
  logic          live;

  assign live  = en && (cur_cnt != '0);
  assign ready = pend && live;

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      len      <= '0;
      cur_addr <= '0;
      cur_cnt  <= '0;
      en       <= 1'b0;
      circ     <= 1'b0;
      pend     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      pend <= (pend && !step) || (dev_req && live);
      if (step) begin
        if (cur_cnt == LW'(1)) begin
          if (circ) begin
            cur_addr <= base;
            cur_cnt  <= len;
          end else begin
            cur_addr <= cur_addr + AW'(1);
            cur_cnt  <= '0;
            en       <= 1'b0;
            done     <= 1'b1;
          end
        end else begin
          cur_addr <= cur_addr + AW'(1);
          cur_cnt  <= cur_cnt - LW'(1);
        end
      end
      if (wr_en) begin
        case (wr_sel)
          WR_BASE: begin
            base     <= wr_data[AW-1:0];
            cur_addr <= wr_data[AW-1:0];
          end
          WR_LEN: begin
            len     <= wr_data[LW-1:0];
            cur_cnt <= wr_data[LW-1:0];
          end
          WR_CTRL: begin
            en   <= wr_data[0];
            circ <= wr_data[1];
          end
          default: ;
        endcase
      end
    end
  end

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && cur_cnt > LW'(1)) |=>
      (cur_cnt == $past(cur_cnt) - LW'(1)) && (cur_addr == $past(cur_addr) + AW'(1)));

  p_oneshot_end_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && cur_cnt == LW'(1) && !circ) |=> (done && !en));

  p_circ_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && cur_cnt == LW'(1) && circ) |=>
      (cur_addr == base && cur_cnt == len && en && !done));

  p_ignore_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !pend) |=> !pend);
endmodule

// File: rtl/dma_steal_arb.sv
module dma_steal_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] ready,
  output logic           any,
  output logic [CHW-1:0] pick
);
  always_comb begin
    any  = |ready;
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ready[i]) pick = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_steal_bus.sv
module dma_steal_bus
  import dma_steal_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = 2,
  parameter int AW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           any,
  input  logic [CHW-1:0] pick,
  input  logic [AW-1:0]  sel_addr,
  input  logic           bus_grant,
  output logic [CHW-1:0] sel,
  output logic           step,
  output logic           bus_req,
  output logic [AW-1:0]  dma_addr,
  output logic           addr_valid,
  output logic [NCH-1:0] dev_strobe
);
  bus_state_t st;

  assign step = (st == BS_REQ) && bus_grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= BS_IDLE;
      sel        <= '0;
      bus_req    <= 1'b0;
      dma_addr   <= '0;
      addr_valid <= 1'b0;
      dev_strobe <= '0;
    end else begin
      case (st)
        BS_IDLE: if (any) begin
          sel     <= pick;
          bus_req <= 1'b1;
          st      <= BS_REQ;
        end
        BS_REQ: if (bus_grant) begin
          dma_addr   <= sel_addr;
          addr_valid <= 1'b1;
          dev_strobe <= NCH'(1) << sel;
          st         <= BS_XFER;
        end
        BS_XFER: begin
          bus_req    <= 1'b0;
          addr_valid <= 1'b0;
          dev_strobe <= '0;
          st         <= BS_REL;
        end
        default: if (!bus_grant) st <= BS_IDLE;
      endcase
    end
  end

  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_strobe) && ((dev_strobe != '0) == addr_valid));

  p_strobe_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_valid) |-> ($past(bus_grant) && bus_req));

  p_release_after_word_r4: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> (!bus_req && !addr_valid));
endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_steal_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int LW  = 16,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int CW  = (AW > LW) ? AW : LW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic [CHW-1:0] rd_ch,
  input  logic [1:0]     rd_sel,
  output logic [CW-1:0]  rd_data,
  input  logic [NCH-1:0] dev_req,
  input  logic           bus_grant,
  output logic           bus_req,
  output logic [AW-1:0]  dma_addr,
  output logic           addr_valid,
  output logic [NCH-1:0] dev_strobe,
  output logic [NCH-1:0] done
);
  logic [AW-1:0]  ch_addr [NCH];
  logic [LW-1:0]  ch_cnt  [NCH];
  logic [NCH-1:0] ch_en, ch_circ, ch_ready;
  logic           any, step;
  logic [CHW-1:0] pick, sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_steal_chan #(.AW(AW), .LW(LW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (cfg_ch == CHW'(i))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .dev_req  (dev_req[i]),
      .step     (step && (sel == CHW'(i))),
      .cur_addr (ch_addr[i]),
      .cur_cnt  (ch_cnt[i]),
      .en       (ch_en[i]),
      .circ     (ch_circ[i]),
      .ready    (ch_ready[i]),
      .done     (done[i])
    );
  end

  dma_steal_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .ready (ch_ready),
    .any   (any),
    .pick  (pick)
  );

  dma_steal_bus #(.NCH(NCH), .CHW(CHW), .AW(AW)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .any        (any),
    .pick       (pick),
    .sel_addr   (ch_addr[sel]),
    .bus_grant  (bus_grant),
    .sel        (sel),
    .step       (step),
    .bus_req    (bus_req),
    .dma_addr   (dma_addr),
    .addr_valid (addr_valid),
    .dev_strobe (dev_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        RD_ADDR: rd_data <= CW'(ch_addr[rd_ch]);
        RD_CNT:  rd_data <= CW'(ch_cnt[rd_ch]);
        RD_CTRL: rd_data <= CW'({ch_circ[rd_ch], ch_en[rd_ch]});
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: tb/dma_steal_test.sv
module dma_steal_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0, cfg_sel = '0, rd_ch = '0, rd_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] rd_data;
  logic [3:0]  dev_req = '0;
  logic        bus_grant = 1'b0;
  logic        bus_req, addr_valid;
  logic [15:0] dma_addr;
  logic [3:0]  dev_strobe, done;

  dma_steal uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .dev_req(dev_req), .bus_grant(bus_grant), .bus_req(bus_req),
    .dma_addr(dma_addr), .addr_valid(addr_valid), .dev_strobe(dev_strobe),
    .done(done)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  typedef struct { int ch; logic [15:0] addr; bit dn; } exp_t;
  exp_t q[$];

  logic [15:0] m_addr [4], m_cnt [4], m_base [4], m_len [4];
  bit          m_en [4], m_circ [4];

  int gdelay = 1;
  int gcnt   = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
    end
  endtask

  // CPU stub: releases the bus gdelay cycles after bus_req, takes it back when bus_req falls
  always @(negedge clk) begin
    if (bus_req) begin
      gcnt      <= gcnt + 1;
      bus_grant <= (gcnt + 1 >= gdelay);
    end else begin
      gcnt      <= 0;
      bus_grant <= 1'b0;
    end
  end

  // Monitor: compares each strobe cycle with the head of the scoreboard
  bit after_strobe = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (after_strobe) chk("R4 bus_req falls after word", bus_req, 0);
      after_strobe = 0;
      if (dev_strobe != 0) begin
        if (q.size() == 0) begin
          chk("R9 unexpected strobe", dev_strobe, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R4 R8 strobe channel", dev_strobe, 32'(4'b1 << e.ch));
          chk("R5 strobe address", dma_addr, e.addr);
          chk("R4 addr_valid", addr_valid, 1);
          chk("R6 done with strobe", done, e.dn ? 32'(4'b1 << e.ch) : 0);
        end
        after_strobe = 1;
      end else if (done != 0) begin
        chk("R6 stray done", done, 0);
      end
    end
  end

  task automatic wr(int ch, int sel, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: begin m_base[ch] = d; m_addr[ch] = d; end
      1: begin m_len[ch] = d; m_cnt[ch] = d; end
      default: begin m_en[ch] = d[0]; m_circ[ch] = d[1]; end
    endcase
  endtask

  task automatic rd(int ch, int sel, output logic [15:0] v);
    @(negedge clk);
    rd_ch = 2'(ch); rd_sel = 2'(sel);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic req(logic [3:0] mask);
    @(negedge clk);
    dev_req = mask;
    for (int i = 0; i < 4; i++) begin
      if (mask[i] && m_en[i] && m_cnt[i] != 0) begin
        exp_t e;
        e.ch = i; e.addr = m_addr[i]; e.dn = 0;
        if (m_cnt[i] == 1) begin
          if (m_circ[i]) begin
            m_addr[i] = m_base[i]; m_cnt[i] = m_len[i];
          end else begin
            m_addr[i] = m_addr[i] + 1; m_cnt[i] = 0; m_en[i] = 0; e.dn = 1;
          end
        end else begin
          m_addr[i] = m_addr[i] + 1; m_cnt[i] = m_cnt[i] - 1;
        end
        q.push_back(e);
      end
    end
    @(negedge clk);
    dev_req = '0;
  endtask

  task automatic drain();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (q.size() == 0 && !bus_req && !bus_grant) break;
    end
    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", q.size(), 0);
  endtask

  task automatic quiet(string what);
    bit saw = 0;
    repeat (12) begin
      @(negedge clk);
      if (bus_req) saw = 1;
    end
    chk(what, saw, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = 0; m_cnt[i] = 0; m_base[i] = 0; m_len[i] = 0; m_en[i] = 0; m_circ[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 strobe after reset", dev_strobe, 0);
    chk("R1 done after reset", done, 0);
    rd(0, 0, v); chk("R1 current address", v, 0);
    rd(3, 1, v); chk("R1 current count", v, 0);
    rd(2, 2, v); chk("R1 control", v, 0);

    // R2: programming and readback
    wr(0, 0, 16'h1000); wr(0, 1, 16'd3); wr(0, 2, 16'h0001);
    rd(0, 0, v); chk("R2 current address loaded", v, 16'h1000);
    rd(0, 1, v); chk("R2 current count loaded", v, 3);
    rd(0, 2, v); chk("R2 control readback", v, 1);

    // R3: no strobe until the CPU releases the bus
    gdelay = 4;
    req(4'b0001);
    for (int k = 0; k < 20 && !bus_req; k++) @(negedge clk);
    chk("R3 bus_req raised", bus_req, 1);
    chk("R3 grant still low", bus_grant, 0);
    chk("R3 no strobe before grant", dev_strobe, 0);
    @(negedge clk);
    chk("R3 no strobe while waiting", dev_strobe, 0);
    drain();
    rd(0, 0, v); chk("R5 address stepped", v, 16'h1001);
    rd(0, 1, v); chk("R5 count stepped", v, 2);

    // R6: one-shot end
    gdelay = 1;
    req(4'b0001); drain();
    req(4'b0001); drain();
    rd(0, 2, v); chk("R6 enable cleared", v, 0);
    rd(0, 1, v); chk("R6 count at zero", v, 0);
    req(4'b0001);
    quiet("R9 request on finished channel ignored");

    // R7: circular reload
    wr(1, 0, 16'h2000); wr(1, 1, 16'd2); wr(1, 2, 16'h0003);
    req(4'b0010); drain();
    req(4'b0010); drain();
    rd(1, 0, v); chk("R7 address reloaded", v, 16'h2000);
    rd(1, 1, v); chk("R7 count reloaded", v, 2);
    rd(1, 2, v); chk("R7 stays enabled", v, 3);
    req(4'b0010); drain();

    // R8: fixed priority among simultaneous requests
    gdelay = 2;
    wr(3, 0, 16'h3000); wr(3, 1, 16'd4); wr(3, 2, 16'h0001);
    wr(2, 0, 16'h4000); wr(2, 1, 16'd4); wr(2, 2, 16'h0001);
    req(4'b1110); drain();
    req(4'b1100); drain();
    rd(3, 0, v); chk("R8 channel 3 served twice", v, 16'h3002);

    // R9: disabled channel and zero-count channel
    wr(2, 2, 16'h0000);
    req(4'b0100);
    quiet("R9 disabled channel ignored");
    wr(2, 1, 16'd0); wr(2, 2, 16'h0001);
    req(4'b0100);
    quiet("R9 zero-count channel ignored");
    chk("R9 no queued transfers", q.size(), 0);

    summary();
    $finish;
  end
endmodule